// File: doc/BRIEF.md
# SPI Initiator Byte Framing Sequencer

This block decides when an SPI initiator shifts each byte, when it opens and closes chip select around a group of bytes, and when it stops. It sits between the transmit and receive FIFOs and a separate byte shift engine. The block looks at FIFO readiness and at the shift engine's byte-complete pulse. It drives a one-cycle byte-start request, a chip-select level, a frame-done pulse and a transfer-done pulse. The shifter, the serial clock generation and the FIFOs belong to other blocks.

The framing setup is a 14-bit byte count, a frame-continue bit and a multi-byte-frame enable. The block captures all three once, when the block enable is set. Together they give three behaviours:
- one counted frame, after which the block stops;
- counted frames that repeat;
- an endless stream.

When multi-byte framing is off, every byte is a frame of its own. The count can still limit how many such frames go out. The block runs only in initiator mode. Clearing the block enable discards the captured setup and all progress.

Top module: `spi_frame_seq`

## Requirements
- R1: A byte-start pulse is issued only if, in the cycle before it, the transmit side was ready (tx_not_empty high, or rx_only high) and rx_not_full was high. The pulse lasts exactly one cycle. No new byte starts until byte_done has closed the previous byte.
- R2: cs_active rises together with the first byte_start of a frame. It stays high between the bytes of that frame. It falls in the cycle after the byte_done of the frame's last byte. Between two frames it stays low for at least one cycle.
- R3: With multi_byte_en=1, frame_cont=0 and a count N>0, exactly N bytes go out in one frame, followed by one frame_done and one xfer_done. After that no byte starts until the enable is cleared and set again, and byte_done pulses while stopped have no effect.
- R4: With multi_byte_en=1, frame_cont=1 and N>0, the block sends frames of N bytes each, one after another, with a frame_done after each frame and never an xfer_done.
- R5: With multi_byte_en=1 and a count of 0, frame_cont has no effect. All bytes form one endless frame: cs_active stays high and neither frame_done nor xfer_done occurs.
- R6: With multi_byte_en=0, every byte is its own frame with its own frame_done. With frame_cont=0 and N>0 the block stops after N such frames and signals xfer_done. With a count of 0 or frame_cont=1 it never stops.
- R7: byte_count, frame_cont and multi_byte_en are captured on the first cycle that blk_en is high. The first byte can start one cycle later at the earliest. Changes to these inputs while blk_en stays high have no effect.
- R8: While blk_en or initiator_mode is low, cs_active, byte_start, frame_done and xfer_done are low from the next cycle on, and the in-frame and total byte progress is cleared. Once initiator_mode returns, the next transfer starts with a fresh frame and a fresh count.
- R9: frame_done and xfer_done are one-cycle pulses issued in the same cycle in which cs_active falls. xfer_done only occurs together with frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Block enable; low clears setup and progress |
| initiator_mode | input | 1 | High when the port acts as initiator |
| multi_byte_en | input | 1 | 1: frames may span several bytes; 0: one byte per frame |
| frame_cont | input | 1 | 1: repeat counted frames; 0: a single counted frame |
| byte_count | input | 14 | Bytes per frame or per transfer; 0 means unbounded |
| rx_only | input | 1 | Receive-only operation, transmit FIFO state ignored |
| tx_not_empty | input | 1 | Transmit FIFO holds data |
| rx_not_full | input | 1 | Receive FIFO has room |
| byte_done | input | 1 | Shift engine finished the current byte |
| byte_start | output | 1 | One-cycle request to shift one byte |
| cs_active | output | 1 | Chip select asserted (active high here) |
| frame_done | output | 1 | One-cycle pulse at each frame end |
| xfer_done | output | 1 | One-cycle pulse when a counted transfer completes |

## Verification
The bench targets these corner cases:
- **Last byte of a frame.** A design that is off by one there would send N-1 or N+1 bytes, or release chip select a cycle early.
- **Stopped state.** A design that leaves it on a stray byte_done, or on a later change of byte_count, would start extra bytes.
- **Streaming setup (count of 0).** A design that misreads this setup would emit spurious frame_done pulses or drop chip select.
- **Single-byte framing with a count.** A design that mishandles it would either never stop or send all bytes under one chip select.
- **Initiator mode dropped mid-frame.** A design that keeps its progress across this event would end the next transfer early.
- **FIFO stalls.** A stall must hold off byte starts but must not close the frame.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BUSY = 3'd1,
    ST_HOLD = 3'd2,
    ST_GAP  = 3'd3,
    ST_STOP = 3'd4
  } seq_state_e;

  function automatic logic fifo_ready(input logic rx_only,
                                      input logic tx_not_empty,
                                      input logic rx_not_full);
    return (tx_not_empty | rx_only) & rx_not_full;
  endfunction

endpackage

// File: rtl/spi_frame_cfg.sv
module spi_frame_cfg #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_en,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             frame_cont,
  input  logic             multi_byte_en,
  output logic             loaded,
  output logic [CNT_W-1:0] cfg_cnt,
  output logic             cfg_cont,
  output logic             cfg_mb
);

  logic             loaded_q, loaded_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cont_q, cont_d;
  logic             mb_q, mb_d;

  always_comb begin
    loaded_d = loaded_q;
    cnt_d    = cnt_q;
    cont_d   = cont_q;
    mb_d     = mb_q;
    if (!blk_en) begin
      loaded_d = 1'b0;
      cnt_d    = '0;
      cont_d   = 1'b0;
      mb_d     = 1'b0;
    end else if (!loaded_q) begin
      loaded_d = 1'b1;
      cnt_d    = byte_count;
      cont_d   = frame_cont;
      mb_d     = multi_byte_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      cnt_q    <= '0;
      cont_q   <= 1'b0;
      mb_q     <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
      cnt_q    <= cnt_d;
      cont_q   <= cont_d;
      mb_q     <= mb_d;
    end
  end

  assign loaded   = loaded_q;
  assign cfg_cnt  = cnt_q;
  assign cfg_cont = cont_q;
  assign cfg_mb   = mb_q;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && blk_en) |=> ($stable(cnt_q) && $stable(cont_q) && $stable(mb_q))); // R7
  AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |=> (!loaded_q && cnt_q == '0)); // R8

endmodule

// File: rtl/spi_frame_cnt.sv
module spi_frame_cnt #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] val
);

  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (clr)      val_d = '0;
    else if (inc) val_d = val_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val = val_q;

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
  import spi_frame_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ready,
  input  logic byte_done,
  input  logic frame_end,
  input  logic stop_now,
  output logic byte_start,
  output logic cs_active,
  output logic frame_done,
  output logic xfer_done,
  output logic byte_closed
);

  seq_state_e st_q, st_d;
  logic start_q, start_d;
  logic cs_q, cs_d;
  logic fd_q, fd_d;
  logic xd_q, xd_d;

  assign byte_closed = run && (st_q == ST_BUSY) && byte_done;

  always_comb begin
    st_d    = st_q;
    cs_d    = cs_q;
    start_d = 1'b0;
    fd_d    = 1'b0;
    xd_d    = 1'b0;
    if (!run) begin
      st_d = ST_IDLE;
      cs_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (ready) begin
            st_d    = ST_BUSY;
            cs_d    = 1'b1;
            start_d = 1'b1;
          end
        end
        ST_BUSY: begin
          if (byte_done) begin
            if (frame_end) begin
              cs_d = 1'b0;
              fd_d = 1'b1;
              xd_d = stop_now;
              st_d = stop_now ? ST_STOP : ST_GAP;
            end else begin
              st_d = ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (ready) begin
            st_d    = ST_BUSY;
            start_d = 1'b1;
          end
        end
        ST_GAP:  st_d = ST_IDLE;
        ST_STOP: st_d = ST_STOP;
        default: begin
          st_d = ST_IDLE;
          cs_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cs_q    <= 1'b0;
      start_q <= 1'b0;
      fd_q    <= 1'b0;
      xd_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cs_q    <= cs_d;
      start_q <= start_d;
      fd_q    <= fd_d;
      xd_q    <= xd_d;
    end
  end

  assign byte_start = start_q;
  assign cs_active  = cs_q;
  assign frame_done = fd_q;
  assign xfer_done  = xd_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R1
  AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(ready && run)); // R1
  AST_CS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> cs_q); // R2
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |=> !cs_q); // R2
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!cs_q && !start_q && !fd_q && !xd_q)); // R8
  AST_DONE_DROPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    fd_q |-> (!cs_q && $past(cs_q))); // R9
  AST_XFER_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    xd_q |-> fd_q); // R9
  AST_FD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fd_q |=> !fd_q); // R9

endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_frame_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_en,
  input  logic             initiator_mode,
  input  logic             multi_byte_en,
  input  logic             frame_cont,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             rx_only,
  input  logic             tx_not_empty,
  input  logic             rx_not_full,
  input  logic             byte_done,
  output logic             byte_start,
  output logic             cs_active,
  output logic             frame_done,
  output logic             xfer_done
);

  localparam int NCNT   = 2;
  localparam int IX_FRM = 0;
  localparam int IX_TOT = 1;

  logic             loaded;
  logic [CNT_W-1:0] cfg_cnt;
  logic             cfg_cont;
  logic             cfg_mb;
  logic             run;
  logic             ready;
  logic             byte_closed;
  logic             frame_end;
  logic             stop_now;
  logic             cnt_zero;
  logic [NCNT-1:0]  c_clr;
  logic [NCNT-1:0]  c_inc;
  logic [CNT_W-1:0] c_val [NCNT];

  spi_frame_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .blk_en        (blk_en),
    .byte_count    (byte_count),
    .frame_cont    (frame_cont),
    .multi_byte_en (multi_byte_en),
    .loaded        (loaded),
    .cfg_cnt       (cfg_cnt),
    .cfg_cont      (cfg_cont),
    .cfg_mb        (cfg_mb)
  );

  assign run      = blk_en & loaded & initiator_mode;
  assign ready    = fifo_ready(rx_only, tx_not_empty, rx_not_full);
  assign cnt_zero = (cfg_cnt == '0);

  assign frame_end = !cfg_mb ||
                     (!cnt_zero && ((c_val[IX_FRM] + CNT_W'(1)) == cfg_cnt));
  assign stop_now  = frame_end && !cfg_cont && !cnt_zero &&
                     ((c_val[IX_TOT] + CNT_W'(1)) == cfg_cnt);

  assign c_inc[IX_FRM] = byte_closed;
  assign c_inc[IX_TOT] = byte_closed;
  assign c_clr[IX_FRM] = !run || (byte_closed && frame_end);
  assign c_clr[IX_TOT] = !run;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    spi_frame_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (c_clr[i]),
      .inc   (c_inc[i]),
      .val   (c_val[i])
    );
  end

  spi_frame_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .ready       (ready),
    .byte_done   (byte_done),
    .frame_end   (frame_end),
    .stop_now    (stop_now),
    .byte_start  (byte_start),
    .cs_active   (cs_active),
    .frame_done  (frame_done),
    .xfer_done   (xfer_done),
    .byte_closed (byte_closed)
  );

  AST_STREAM_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && blk_en && cfg_mb && cnt_zero) |=> !frame_done); // R5
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_closed && cfg_mb && !cnt_zero) |-> (c_val[IX_FRM] < cfg_cnt)); // R4

endmodule

// File: tb/sim_spi_frame_seq.sv
module sim_spi_frame_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int CW         = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          blk_en, initiator_mode, multi_byte_en, frame_cont;
  logic [CW-1:0] byte_count;
  logic          rx_only, tx_not_empty, rx_not_full, byte_done;
  logic          byte_start, cs_active, frame_done, xfer_done;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R0";
  bit fin = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .initiator_mode(initiator_mode),
    .multi_byte_en(multi_byte_en), .frame_cont(frame_cont), .byte_count(byte_count),
    .rx_only(rx_only), .tx_not_empty(tx_not_empty), .rx_not_full(rx_not_full),
    .byte_done(byte_done), .byte_start(byte_start), .cs_active(cs_active),
    .frame_done(frame_done), .xfer_done(xfer_done)
  );

  // Behavioural reference: phase 0 idle, 1 shifting, 2 between bytes, 3 gap, 4 finished
  int m_phase, m_len, m_infrm, m_sent;
  bit m_have, m_rep, m_multi;
  bit e_start, e_cs, e_fd, e_xd;
  bit m_run, m_rdy, m_last, m_end;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_len = 0; m_infrm = 0; m_sent = 0;
      m_have = 0; m_rep = 0; m_multi = 0;
      e_start = 0; e_cs = 0; e_fd = 0; e_xd = 0;
    end else begin
      m_run = blk_en && m_have && initiator_mode;
      m_rdy = (tx_not_empty || rx_only) && rx_not_full;
      e_start = 0; e_fd = 0; e_xd = 0;
      if (!m_run) begin
        m_phase = 0; e_cs = 0; m_infrm = 0; m_sent = 0;
      end else if (m_phase == 0 || m_phase == 2) begin
        if (m_rdy) begin
          if (m_phase == 0) e_cs = 1;
          m_phase = 1; e_start = 1;
        end
      end else if (m_phase == 1) begin
        if (byte_done) begin
          m_infrm++; m_sent++;
          m_last = !m_multi || (m_len != 0 && m_infrm == m_len);
          m_end  = m_last && !m_rep && m_len != 0 && m_sent == m_len;
          if (m_last) begin
            m_infrm = 0; e_cs = 0; e_fd = 1; e_xd = m_end;
            m_phase = m_end ? 4 : 3;
          end else m_phase = 2;
        end
      end else if (m_phase == 3) m_phase = 0;
      if (!blk_en) begin
        m_have = 0; m_len = 0; m_rep = 0; m_multi = 0;
      end else if (!m_have) begin
        m_have = 1; m_len = int'(byte_count); m_rep = frame_cont; m_multi = multi_byte_en;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Observation counters and shift-engine emulation
  int o_start, o_fd, o_xd, o_csfall;
  int lat_cnt = 0;
  bit inj_done = 0;
  bit cs_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "byte_start", int'(byte_start), int'(e_start));
      chk(cur_req, "cs_active",  int'(cs_active),  int'(e_cs));
      chk(cur_req, "frame_done", int'(frame_done), int'(e_fd));
      chk(cur_req, "xfer_done",  int'(xfer_done),  int'(e_xd));
      if (byte_start) o_start++;
      if (frame_done) o_fd++;
      if (xfer_done) o_xd++;
      if (cs_prev && !cs_active) o_csfall++;
    end
    cs_prev = cs_active;
    if (lat_cnt == 1) begin byte_done = 1; lat_cnt = 0; end
    else begin
      byte_done = inj_done;
      if (lat_cnt > 1) lat_cnt--;
    end
    inj_done = 0;
    if (byte_start) lat_cnt = LAT;
  end

  task automatic clr_obs();
    o_start = 0; o_fd = 0; o_xd = 0; o_csfall = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input bit mb, input bit cont, input int cnt);
    @(negedge clk);
    blk_en = 0;
    cyc(2);
    multi_byte_en = mb; frame_cont = cont; byte_count = CW'(cnt);
    blk_en = 1;
    clr_obs();
  endtask

  initial begin
    rst_n = 0; blk_en = 0; initiator_mode = 1; multi_byte_en = 0; frame_cont = 0;
    byte_count = '0; rx_only = 0; tx_not_empty = 1; rx_not_full = 1; byte_done = 0;
    clr_obs();
    cyc(3);
    chk("R8", "reset cs_active", int'(cs_active), 0);
    chk("R8", "reset byte_start", int'(byte_start), 0);
    rst_n = 1;
    cyc(2);

    // R3: one counted frame of 3 bytes, then stopped
    cur_req = "R3";
    setup(1, 0, 3);
    cyc(40);
    chk("R3", "bytes in single frame", o_start, 3);
    chk("R3", "frame_done count", o_fd, 1);
    chk("R3", "xfer_done count", o_xd, 1);
    chk("R9", "cs falls once", o_csfall, 1);
    // R7: count changes while enabled are ignored; stray byte_done ignored (R3)
    cur_req = "R7";
    clr_obs();
    byte_count = CW'(5);
    inj_done = 1;
    cyc(30);
    chk("R7", "no restart after count change", o_start, 0);
    chk("R3", "stray byte_done ignored", o_fd, 0);

    // R4: repeated frames of 2, with a FIFO stall for R1
    cur_req = "R4";
    setup(1, 1, 2);
    cyc(60);
    chk("R4", "no xfer_done when repeating", o_xd, 0);
    chk("R4", "frames of two bytes", o_start - 2 * o_fd <= 2 ? 1 : 0, 1);
    chk("R4", "several frames", o_fd >= 3 ? 1 : 0, 1);
    cur_req = "R1";
    tx_not_empty = 0;
    cyc(8);
    clr_obs();
    cyc(20);
    chk("R1", "no start with tx empty", o_start, 0);
    rx_only = 1;
    cyc(20);
    chk("R1", "rx_only starts bytes", o_start > 0 ? 1 : 0, 1);
    rx_not_full = 0;
    cyc(8);
    clr_obs();
    cyc(20);
    chk("R1", "no start with rx full", o_start, 0);
    rx_not_full = 1; rx_only = 0; tx_not_empty = 1;

    // R5: count 0 streams in one endless frame
    cur_req = "R5";
    setup(1, 1, 0);
    cyc(80);
    chk("R5", "stream frame_done", o_fd, 0);
    chk("R5", "stream keeps cs", int'(cs_active), 1);
    chk("R5", "stream bytes", o_start >= 10 ? 1 : 0, 1);

    // R6: one byte per frame, stop after 4
    cur_req = "R6";
    setup(0, 0, 4);
    cyc(80);
    chk("R6", "single-byte frames", o_fd, 4);
    chk("R6", "bytes", o_start, 4);
    chk("R6", "xfer_done", o_xd, 1);
    chk("R2", "cs toggles per byte", o_csfall, 4);
    setup(0, 1, 4);
    cyc(80);
    chk("R6", "repeat never stops", o_xd, 0);
    chk("R6", "repeat keeps going", o_fd >= 6 ? 1 : 0, 1);

    // R8: drop initiator mode mid-frame, progress restarts
    cur_req = "R8";
    setup(1, 0, 3);
    cyc(6);
    initiator_mode = 0;
    cyc(2);
    chk("R8", "cs low in target mode", int'(cs_active), 0);
    clr_obs();
    cyc(10);
    chk("R8", "no start in target mode", o_start, 0);
    initiator_mode = 1;
    cyc(50);
    chk("R8", "fresh count after return", o_start, 3);
    chk("R8", "xfer after return", o_xd, 1);
    blk_en = 0;
    cyc(3);
    chk("R8", "disabled cs", int'(cs_active), 0);

    fin = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule